// File: doc/BRIEF.md
# SDIO Card Clock Generator

This block derives the card-facing bus clock from a master clock. A small control register, written from a host port, sets a divide value, turns the clock on or off, can pass the master clock straight through, and can gate the clock off while the bus is idle. It also picks which master-clock edge launches the card clock and decodes the data-bus width for the rest of the interface.

In divided mode the card clock period is the divide field plus two master cycles. The high phase is the shorter half when the total is odd. Every start, stop and divide change falls on a period boundary, so the card never sees a short pulse. A one-cycle strobe marks the master cycle that launches each rising card-clock edge, for logic that prefers a clock enable to a derived clock. The control register refuses writes for seven host cycles after any accepted write.

Top module: `sdclk_gen`

## Requirements
- R1: After reset every control field is zero. The card clock and the enable strobe are low, and the width output reports 1 line.
- R2: With the bypass bit clear, the card clock period is N = DIV+2 master cycles. The high phase lasts floor(N/2) cycles and the low phase lasts the remaining cycles. DIV is bits 6:0 of the control word.
- R3: With the bypass bit (bit 9) set and the clock enabled, the card clock follows the master clock and DIV has no effect. With the edge bit set, it follows the inverted master clock.
- R4: Clearing the enable bit (bit 7) stops the card clock at the end of the current period, and the clock then stays low.
- R5: With the idle-gate bit (bit 8) set, the clock runs only while bus_busy is high. When bus_busy drops, the running period completes and the clock then stays low.
- R6: With the edge bit (bit 10) clear, card-clock transitions follow rising master edges. With it set, they follow falling master edges, half a master cycle later.
- R7: Width field bits 12:11 decode as 00 to 1 line, 01 to 4 lines and 10 to 8 lines. The reserved code 11 reports 1 line.
- R8: A write that arrives in any of the 7 host cycles after an accepted write is dropped. The write in the 8th cycle is accepted.
- R9: A new DIV value written while the clock runs takes effect only at the next period boundary.
- R10: A start from the stopped state begins one master cycle after the run condition appears, with a full-length high phase.
- R11: In divided mode, clk_en pulses for one master cycle in each cycle where the card clock rises on a rising master edge. In bypass mode it is high while the clock is gated on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master and host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 13 | Control word: width[12:11], edge[10], bypass[9], idle-gate[8], enable[7], DIV[6:0] |
| bus_busy | input | 1 | Bus activity from the command/data path |
| card_clk | output | 1 | Card bus clock |
| clk_en | output | 1 | Clock-enable strobe matching card-clock rising edges |
| width_lines | output | 4 | Decoded data line count (1, 4 or 8) |

## Verification
The bench sweeps DIV from 0 to 9 under both edge selections and measures the lengths of the high and low runs. An off-by-one divider or the wrong odd-split rounding would show up as wrong phase lengths. It changes DIV, drops enable and drops bus_busy just after a rising edge. A design that applies the change at once would cut the current period short or leave a short pulse. It hammers the register during the lockout window and checks the eighth cycle. A counter that is one cycle off would either accept a write that should be dropped or drop the one that should land. Bypass is checked at both phases of the master clock, which catches a bypass path still routed through the divider.

// File: rtl/sdclk_pkg.sv
// Shared types for the card clock generator.
// Assumes the control word is 13 bits, with its fields packed as below.
package sdclk_pkg;

    localparam int DIV_W  = 7;
    localparam int CTRL_W = DIV_W + 6;

    // Control register image, most significant field first.
    typedef struct packed {
        logic [1:0]       width;     // bus width code
        logic             neg_edge;  // launch on falling master edge
        logic             bypass;    // master clock passes straight through
        logic             idle_gate; // run only while the bus is busy
        logic             en;        // clock enable
        logic [DIV_W-1:0] div;       // divide field, period = div + 2
    } ctrl_t;

    // Turns the width code into a data line count.
    function automatic logic [3:0] lines_of(input logic [1:0] code);
        case (code)
            2'b01:   lines_of = 4'd4;
            2'b10:   lines_of = 4'd8;
            default: lines_of = 4'd1;
        endcase
    endfunction

endpackage

// File: rtl/sdclk_regs.sv
// Control register with a write lockout.
// After each accepted write, further writes are dropped for LOCK_CYC cycles.
// Assumes the host port runs on the master clock.
module sdclk_regs
    import sdclk_pkg::*;
#(
    parameter int LOCK_CYC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl_q
);

    localparam int LW = $clog2(LOCK_CYC + 1);

    logic [LW-1:0] lock_q;
    logic          accept;

    assign accept = wr_en && (lock_q == '0);

    // Loads the register on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (accept) ctrl_q <= ctrl_t'(wr_data);
    end

    // Counts down the lockout window after an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)              lock_q <= '0;
        else if (accept)         lock_q <= LW'(LOCK_CYC);
        else if (lock_q != '0)   lock_q <= lock_q - 1'b1;
    end

    // R8
    wr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q != '0) |=> $stable(ctrl_q));

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (ctrl_q == '0));

endmodule

// File: rtl/sdclk_div.sv
// Period engine for divided mode.
// It runs a counter over N = div + 2 cycles and drives a registered high phase
// for the first floor(N/2) counts. The divide value is captured only at the
// start of a period. Starting and stopping happen only on period boundaries,
// which always sit in the low phase.
module sdclk_div
    import sdclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_req,
    input  logic [DIV_W-1:0] div_cfg,
    output logic             hi_q,
    output logic             rise_q
);

    localparam int CW = DIV_W + 1;

    logic             run_q,  nxt_run;
    logic [CW-1:0]    cnt_q,  nxt_cnt;
    logic [DIV_W-1:0] dact_q, nxt_dact;
    logic [CW-1:0]    n_act,  nxt_half;
    logic             last,   nxt_hi;

    assign n_act    = CW'(dact_q) + CW'(2);
    assign last     = (cnt_q == n_act - CW'(1));
    assign nxt_half = (CW'(nxt_dact) + CW'(2)) >> 1;

    // Works out the next counter, run flag and active divide value.
    always_comb begin
        nxt_run  = run_q;
        nxt_cnt  = cnt_q;
        nxt_dact = dact_q;
        if (!run_q) begin
            if (run_req) begin
                nxt_run  = 1'b1;
                nxt_cnt  = '0;
                nxt_dact = div_cfg;
            end
        end else if (last) begin
            nxt_cnt = '0;
            if (run_req) nxt_dact = div_cfg;
            else         nxt_run  = 1'b0;
        end else begin
            nxt_cnt = cnt_q + CW'(1);
        end
        nxt_hi = nxt_run && (nxt_cnt < nxt_half);
    end

    // Registers the period state and a glitch-free output phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            dact_q <= '0;
            hi_q   <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            run_q  <= nxt_run;
            cnt_q  <= nxt_cnt;
            dact_q <= nxt_dact;
            hi_q   <= nxt_hi;
            rise_q <= nxt_hi && !hi_q;
        end
    end

    // R9
    div_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dact_q) |-> (cnt_q == '0));

    // R10
    rise_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_q) |-> (cnt_q == '0) && run_q);

    // R4
    stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> !$past(hi_q));

endmodule

// File: rtl/sdclk_out.sv
// Output stage. It selects between the divided phase and the gated master
// clock, and picks the launch edge. The bypass gates change only while the
// clock they gate is low, so gating leaves no partial pulse.
// Assumes the bypass bit is changed only while the clock is stopped.
module sdclk_out (
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    input  logic bypass,
    input  logic neg_edge,
    input  logic hi_q,
    input  logic rise_q,
    output logic card_clk,
    output logic clk_en
);

    logic g_hi;  // gate updated while the inverted clock is low
    logic g_lo;  // gate updated while the master clock is low
    logic hi_n;  // divided phase moved onto the falling edge

    // Samples the run request on the rising edge, for the inverted bypass.
    always_ff @(posedge clk) begin
        if (!rst_n) g_hi <= 1'b0;
        else        g_hi <= run_req;
    end

    // Samples the run request and divided phase on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            g_lo <= 1'b0;
            hi_n <= 1'b0;
        end else begin
            g_lo <= run_req;
            hi_n <= hi_q;
        end
    end

    // Chooses the card clock source and the strobe.
    always_comb begin
        if (bypass) begin
            card_clk = neg_edge ? (~clk & g_hi) : (clk & g_lo);
            clk_en   = g_hi;
        end else begin
            card_clk = neg_edge ? hi_n : hi_q;
            clk_en   = rise_q;
        end
    end

endmodule

// File: rtl/sdclk_gen.sv
// Top of the card clock generator.
// It ties the control register, the period engine and the output stage
// together. The run condition combines enable with the idle-bus gate.
// Assumes a single master clock shared with the host register port.
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter int LOCK_CYC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              bus_busy,
    output logic              card_clk,
    output logic              clk_en,
    output logic [3:0]        width_lines
);

    ctrl_t ctrl_q;
    logic  run_req;
    logic  hi_q;
    logic  rise_q;

    // Clock may run when enabled and, if idle-gated, while the bus is busy.
    assign run_req     = ctrl_q.en && (!ctrl_q.idle_gate || bus_busy);
    assign width_lines = lines_of(ctrl_q.width);

    sdclk_regs #(.LOCK_CYC(LOCK_CYC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q)
    );

    sdclk_div u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_req (run_req && !ctrl_q.bypass),
        .div_cfg (ctrl_q.div),
        .hi_q    (hi_q),
        .rise_q  (rise_q)
    );

    sdclk_out u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_req  (run_req),
        .bypass   (ctrl_q.bypass),
        .neg_edge (ctrl_q.neg_edge),
        .hi_q     (hi_q),
        .rise_q   (rise_q),
        .card_clk (card_clk),
        .clk_en   (clk_en)
    );

    // R7
    width_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(width_lines) == 1);

endmodule

// File: tb/sim_sdclk_gen.sv
module sim_sdclk_gen;

    localparam int P = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [12:0] wr_data = '0;
    logic        bus_busy = 1'b0;
    logic        card_clk;
    logic        clk_en;
    logic [3:0]  width_lines;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic ra [0:199];
    logic rb [0:199];
    logic ce [0:199];
    int   ptr = 0;

    always #(P/2) clk = ~clk;

    sdclk_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .bus_busy(bus_busy), .card_clk(card_clk), .clk_en(clk_en),
        .width_lines(width_lines)
    );

    function automatic logic [12:0] mk(int d, bit en, bit gate, bit byp, bit neg, int wid);
        mk = {wid[1:0], neg, byp, gate, en, d[6:0]};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One master cycle: samples a quarter after the rising edge and a quarter after the falling edge.
    task automatic tick();
        @(posedge clk);
        #(P/4);
        if (ptr < 200) begin ra[ptr] = card_clk; ce[ptr] = clk_en; end
        #(P/2);
        if (ptr < 200) begin rb[ptr] = card_clk; ptr++; end
    endtask

    task automatic rec(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(logic [12:0] v);
        wr_en = 1'b1; wr_data = v;
        tick();
        wr_en = 1'b0;
    endtask

    // Waits for a rising card clock seen at the quarter sample, then restarts the record.
    task automatic wait_rise();
        logic prev;
        prev = 1'b1;
        for (int i = 0; i < 80; i++) begin
            ptr = 0;
            tick();
            if (ra[0] && !prev) begin
                ptr = 1;
                return;
            end
            prev = ra[0];
        end
        check(0, "rise", 0, 1);
    endtask

    // Checks three whole periods, starting at the first rise found after index 'from'.
    task automatic periods(bit use_b, int from, int n, string req);
        int start, bad;
        logic s, sp;
        start = -1;
        bad = 0;
        for (int i = from; i < 150; i++) begin
            s  = use_b ? rb[i] : ra[i];
            sp = use_b ? rb[i-1] : ra[i-1];
            if (start < 0 && s && !sp) start = i;
        end
        if (start < 0) bad = 99;
        else for (int j = 0; j < 3*n; j++) begin
            s = use_b ? rb[start+j] : ra[start+j];
            if (s != ((j % n) < (n / 2))) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    initial begin
        #(P * 150000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int bad;
        rec(4);
        rst_n = 1'b1;
        ptr = 0; rec(6);
        // R1 reset state
        bad = 0;
        for (int i = 0; i < 6; i++) bad += int'(ra[i]) + int'(rb[i]) + int'(ce[i]);
        check(bad == 0, "R1 clock low", bad, 0);
        check(width_lines == 4'd1, "R1 width", width_lines, 1);

        // R2, R6, R11: divide sweep under both edges
        for (int d = 0; d < 10; d++) begin
            for (int ng = 0; ng < 2; ng++) begin
                ptr = 0;
                wr(mk(d, 1, 0, 0, ng[0], 0));
                rec(119);
                periods(ng[0], 24, d + 2, ng[0] ? "R6 falling period" : "R2 period");
                bad = 0;
                if (ng == 0) begin
                    for (int i = 24; i < 110; i++) if (ra[i] != rb[i]) bad++;
                    check(bad == 0, "R6 rising edge only", bad, 0);
                    bad = 0;
                    for (int i = 24; i < 110; i++) if (ce[i] != (ra[i] && !ra[i-1])) bad++;
                    check(bad == 0, "R11 strobe", bad, 0);
                end else begin
                    int lag;
                    lag = 0;
                    for (int i = 24; i < 110; i++) begin
                        if (ra[i] != rb[i]) lag++;
                        if (ra[i+1] != rb[i]) bad++;
                    end
                    check(bad == 0 && lag > 0, "R6 half cycle lag", bad, 0);
                end
            end
        end

        // R9: change DIV 8 -> 0 just after a rise
        wr(mk(8, 1, 0, 0, 0, 0)); rec(40);
        wait_rise();
        wr(mk(0, 1, 0, 0, 0, 0));
        rec(24);
        bad = 0;
        for (int j = 0; j < 24; j++)
            if (ra[j] != ((j < 5) ? 1'b1 : (j < 10) ? 1'b0 : ((j - 10) % 2 == 0))) bad++;
        check(bad == 0, "R9 boundary switch", bad, 0);

        // R4: disable just after a rise at N=10
        rec(8);
        wr(mk(8, 1, 0, 0, 0, 0)); rec(40);
        wait_rise();
        wr(mk(8, 0, 0, 0, 0, 0));
        rec(30);
        bad = 0;
        for (int j = 0; j < 30; j++) if (ra[j] != (j < 5)) bad++;
        check(bad == 0, "R4 stop low", bad, 0);

        // R10: start from stopped, N=6
        ptr = 0;
        wr(mk(4, 1, 0, 0, 0, 0));
        ptr = 0;
        rec(18);
        bad = 0;
        for (int j = 0; j < 18; j++) if (ra[j] != ((j % 6) < 3)) bad++;
        check(bad == 0, "R10 clean start", bad, 0);

        // R5: idle gate, N=5
        rec(8);
        wr(mk(3, 1, 1, 0, 0, 0));
        rec(20);
        ptr = 0; rec(30);
        bad = 0;
        for (int j = 0; j < 30; j++) bad += int'(ra[j]);
        check(bad == 0, "R5 idle stays low", bad, 0);
        bus_busy = 1'b1;
        ptr = 0; rec(60);
        periods(0, 2, 5, "R5 busy period");
        wait_rise();
        bus_busy = 1'b0;
        rec(20);
        bad = 0;
        for (int j = 0; j < 20; j++) if (ra[j] != (j < 2)) bad++;
        check(bad == 0, "R5 finish then stop", bad, 0);

        // R3: bypass, both edges, DIV ignored
        wr(mk(5, 0, 0, 0, 0, 0)); rec(20);
        wr(mk(5, 1, 0, 1, 0, 0)); rec(7);
        ptr = 0; rec(6);
        bad = 0;
        for (int j = 0; j < 6; j++) if (!ra[j] || rb[j] || !ce[j]) bad++;
        check(bad == 0, "R3 bypass rising", bad, 0);
        check(ce[0] == 1'b1, "R11 bypass strobe", ce[0], 1);
        wr(mk(5, 0, 0, 1, 0, 0)); rec(7);
        wr(mk(5, 1, 0, 1, 1, 0)); rec(7);
        ptr = 0; rec(6);
        bad = 0;
        for (int j = 0; j < 6; j++) if (ra[j] || !rb[j]) bad++;
        check(bad == 0, "R3 bypass falling", bad, 0);
        wr(mk(5, 0, 0, 1, 0, 0)); rec(7);
        ptr = 0; rec(5);
        bad = 0;
        for (int j = 0; j < 5; j++) bad += int'(ra[j]) + int'(rb[j]);
        check(bad == 0, "R3 bypass disabled", bad, 0);

        // R7: width decode
        for (int w = 0; w < 4; w++) begin
            wr(mk(0, 0, 0, 0, 0, w));
            check(width_lines == ((w == 1) ? 4 : (w == 2) ? 8 : 1), "R7 width", width_lines,
                  (w == 1) ? 4 : (w == 2) ? 8 : 1);
            rec(8);
        end

        // R8: lockout window
        wr(mk(0, 0, 0, 0, 0, 1));
        wr_en = 1'b1; wr_data = mk(0, 0, 0, 0, 0, 2);
        rec(7);
        check(width_lines == 4'd4, "R8 writes dropped", width_lines, 4);
        tick();
        wr_en = 1'b0;
        check(width_lines == 4'd8, "R8 eighth cycle accepted", width_lines, 8);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule